// File: doc/BRIEF.md
# Queue Pointer Controller

This block keeps a read pointer and a write pointer for each queue in a bank of hardware queues, 256 by default. A host on a plain 32-bit register port moves a pointer by writing a small count to that queue's add register, and reads both pointers back from two status registers. Pointers never move one entry at a time. They advance only by these posted counts, modulo a power-of-two size that is programmed per queue.

Every queue has its own 0x800-byte register window, and the bank of windows starts at byte 0x80000 of the port's address space. The block also keeps three sticky flags per queue:

- an error flag for an add count that is too large;
- an overflow flag for a write-side add that would exceed the queue's capacity;
- an underflow flag for a read-side add that would pass the write pointer.

The host clears each flag by writing 1 to its bit. Register reads have one cycle of latency and have no side effects.

Top module: `qptr_ctrl`

## Requirements
- R1: After reset, every queue has read pointer 0, write pointer 0, all three flags 0 and size code 18. Read data is 0.
- R2: The queue bank starts at byte address 0x80000. Queue q is selected by bits [7:0] of (address − 0x80000) / 0x800, so addresses above the bank alias onto the low queues. Below 0x80000, and at any window offset other than 0x0, 0x4, 0x8, 0xC and 0x10, writes have no effect and reads return 0.
- R3: A write of n (0 ≤ n ≤ 63) to window offset 0x0 sets the read pointer to (rp + n) mod size. The add registers at 0x0 and 0x4 read as 0.
- R4: A write of n (0 ≤ n ≤ 63) to window offset 0x4 sets the write pointer to (wp + n) mod size. The value n = 63 is applied in a single write.
- R5: An add value greater than 63 changes neither pointer and sets the queue's sticky error flag.
- R6: Offset 0x8 reads {error flag at bit 31, zeros, read pointer at bits [17:0]}. Offset 0xC reads {overflow at bit 31, underflow at bit 30, zeros, write pointer at bits [17:0]}.
- R7: Offset 0x10 holds a 5-bit size code at bits [4:0] and reads it back. The queue size is 2^min(code,18). Writing the code also truncates both pointers to the new size.
- R8: Let occupancy = (wp − rp) mod size. A valid write-side add of n sets the overflow flag when occupancy + n > size − 1. The write pointer still advances.
- R9: A valid read-side add of n sets the underflow flag when n > occupancy. The read pointer still advances.
- R10: Writing offset 0xC with bit 31 set clears overflow, and with bit 30 set clears underflow. Writing offset 0x8 with bit 31 set clears the error flag. A 0 in any of these bits leaves that flag unchanged.
- R11: The read data present after a clock edge is the register addressed in the cycle before that edge, as it stood before any write taken at that same edge.
- R12: A write changes only the addressed queue. With write enable low, no queue state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 24 | Byte address of the register access |
| busWe | input | 1 | Write strobe for the current cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
Within a single add, the wrap of a pointer past the queue's size boundary coincides with the overflow or underflow decision. Both depend on the occupancy taken modulo the same size. The bench provokes this by programming sizes of 1 to 16 entries and driving counts that carry a pointer across the boundary exactly as capacity is reached or passed. A behavioural reference model then judges the pointer values and the flags on every clock. The bench also writes a status register in the same cycle it is read, so the read data must show the flag value from before the clear.

// File: rtl/qptr_pkg.sv
package qptr_pkg;
  localparam int PTR_W  = 18;
  localparam int CODE_W = 5;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_ADD_RD,
    RK_ADD_WR,
    RK_STAT_LO,
    RK_STAT_HI,
    RK_SIZE
  } regKind_t;

  typedef struct packed {
    logic addRd;
    logic addWr;
    logic statLo;
    logic statHi;
    logic setSize;
  } strobe_t;

  typedef struct packed {
    logic [PTR_W-1:0]  rp;
    logic [PTR_W-1:0]  wp;
    logic [CODE_W-1:0] code;
    logic              err;
    logic              ovf;
    logic              udf;
  } queueState_t;

  localparam queueState_t Q_RESET = '{rp: '0, wp: '0, code: CODE_W'(PTR_W),
                                      err: 1'b0, ovf: 1'b0, udf: 1'b0};

  function automatic logic [PTR_W-1:0] sizeMask(input logic [CODE_W-1:0] code);
    int lg;
    lg = (int'(code) > PTR_W) ? PTR_W : int'(code);
    sizeMask = PTR_W'((64'd1 << lg) - 64'd1);
  endfunction
endpackage

// File: rtl/qptr_decode.sv
module qptr_decode
  import qptr_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_Q       = 256,
  parameter int REGION_BASE = 'h80000,
  parameter int WIN_BYTES   = 'h800
) (
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWe,
  input  logic [DATA_W-1:0]        busWdata,
  output strobe_t                  wrStb,
  output logic [$clog2(NUM_Q)-1:0] wrQ,
  output logic [DATA_W-1:0]        wrVal,
  output regKind_t                 rdKind,
  output logic [$clog2(NUM_Q)-1:0] rdQ
);
  localparam int QIDX_W  = $clog2(NUM_Q);
  localparam int WIN_LOG = $clog2(WIN_BYTES);

  logic [ADDR_W-1:0]  relAddr;
  logic [WIN_LOG-1:0] winOff;
  logic               inRegion;
  logic [QIDX_W-1:0]  qSel;
  regKind_t           kind;

  assign inRegion = busAddr >= ADDR_W'(REGION_BASE);
  assign relAddr  = busAddr - ADDR_W'(REGION_BASE);
  assign qSel     = relAddr[WIN_LOG +: QIDX_W];
  assign winOff   = busAddr[WIN_LOG-1:0];

  always_comb begin
    kind = RK_NONE;
    if (inRegion) begin
      case (winOff)
        WIN_LOG'('h00): kind = RK_ADD_RD;
        WIN_LOG'('h04): kind = RK_ADD_WR;
        WIN_LOG'('h08): kind = RK_STAT_LO;
        WIN_LOG'('h0C): kind = RK_STAT_HI;
        WIN_LOG'('h10): kind = RK_SIZE;
        default:        kind = RK_NONE;
      endcase
    end
  end

  always_comb begin
    wrStb         = '0;
    wrStb.addRd   = busWe && (kind == RK_ADD_RD);
    wrStb.addWr   = busWe && (kind == RK_ADD_WR);
    wrStb.statLo  = busWe && (kind == RK_STAT_LO);
    wrStb.statHi  = busWe && (kind == RK_STAT_HI);
    wrStb.setSize = busWe && (kind == RK_SIZE);
  end

  assign wrQ    = qSel;
  assign wrVal  = busWdata;
  assign rdKind = kind;
  assign rdQ    = qSel;
endmodule

// File: rtl/qptr_slot.sv
module qptr_slot
  import qptr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        load,
  input  queueState_t nextSt,
  output queueState_t st
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     st <= Q_RESET;
    else if (load) st <= nextSt;
  end
endmodule

// File: rtl/qptr_datapath.sv
module qptr_datapath
  import qptr_pkg::*;
#(
  parameter int NUM_Q   = 256,
  parameter int MAX_ADD = 63
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  wrStb,
  input  logic [$clog2(NUM_Q)-1:0] wrQ,
  input  logic [DATA_W-1:0]        wrVal,
  input  regKind_t                 rdKind,
  input  logic [$clog2(NUM_Q)-1:0] rdQ,
  output logic [DATA_W-1:0]        rdData
);
  localparam int QIDX_W  = $clog2(NUM_Q);
  localparam int ERR_BIT = DATA_W - 1;
  localparam int OVF_BIT = DATA_W - 1;
  localparam int UDF_BIT = DATA_W - 2;

  queueState_t qSt [NUM_Q];
  queueState_t cur, nxt;
  logic [PTR_W-1:0] mask, occ, cnt, newMask;
  logic             tooBig, anyStb;

  assign anyStb = |wrStb;
  assign cur    = qSt[wrQ];
  assign mask   = sizeMask(cur.code);
  assign occ    = (cur.wp - cur.rp) & mask;
  assign tooBig = wrVal > DATA_W'(MAX_ADD);
  assign cnt    = wrVal[PTR_W-1:0];

  always_comb begin
    nxt     = cur;
    newMask = sizeMask(wrVal[CODE_W-1:0]);
    if (wrStb.addRd) begin
      if (tooBig) nxt.err = 1'b1;
      else begin
        if (cnt > occ) nxt.udf = 1'b1;
        nxt.rp = (cur.rp + cnt) & mask;
      end
    end
    if (wrStb.addWr) begin
      if (tooBig) nxt.err = 1'b1;
      else begin
        if ({1'b0, occ} + {1'b0, cnt} > {1'b0, mask}) nxt.ovf = 1'b1;
        nxt.wp = (cur.wp + cnt) & mask;
      end
    end
    if (wrStb.statLo && wrVal[ERR_BIT]) nxt.err = 1'b0;
    if (wrStb.statHi) begin
      if (wrVal[OVF_BIT]) nxt.ovf = 1'b0;
      if (wrVal[UDF_BIT]) nxt.udf = 1'b0;
    end
    if (wrStb.setSize) begin
      nxt.code = wrVal[CODE_W-1:0];
      nxt.rp   = cur.rp & newMask;
      nxt.wp   = cur.wp & newMask;
    end
  end

  for (genvar i = 0; i < NUM_Q; i++) begin : gSlot
    qptr_slot uSlot (
      .clk    (clk),
      .rstN   (rstN),
      .load   (anyStb && (wrQ == QIDX_W'(i))),
      .nextSt (nxt),
      .st     (qSt[i])
    );
  end

  queueState_t rs;
  logic [DATA_W-1:0] rdWord;
  assign rs = qSt[rdQ];

  always_comb begin
    rdWord = '0;
    case (rdKind)
      RK_STAT_LO: begin
        rdWord[PTR_W-1:0] = rs.rp;
        rdWord[ERR_BIT]   = rs.err;
      end
      RK_STAT_HI: begin
        rdWord[PTR_W-1:0] = rs.wp;
        rdWord[OVF_BIT]   = rs.ovf;
        rdWord[UDF_BIT]   = rs.udf;
      end
      RK_SIZE: rdWord[CODE_W-1:0] = rs.code;
      default: rdWord = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdWord;
  end

  AST_REJECT_KEEPS_PTRS: assert property (@(posedge clk) disable iff (!rstN)
    ((wrStb.addRd || wrStb.addWr) && tooBig) |=>
      (qSt[$past(wrQ)].rp == $past(cur.rp)) && (qSt[$past(wrQ)].wp == $past(cur.wp))); // R5
  AST_ERR_STICKY_SET: assert property (@(posedge clk) disable iff (!rstN)
    ((wrStb.addRd || wrStb.addWr) && tooBig) |=> qSt[$past(wrQ)].err); // R5
  AST_WP_WITHIN_SIZE: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.addWr && !tooBig) |=> ((qSt[$past(wrQ)].wp & ~$past(mask)) == '0)); // R4
  AST_OVF_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb.statHi && wrVal[OVF_BIT]) |=> !qSt[$past(wrQ)].ovf); // R10
endmodule

// File: rtl/qptr_ctrl.sv
module qptr_ctrl
  import qptr_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_Q       = 256,
  parameter int REGION_BASE = 'h80000,
  parameter int WIN_BYTES   = 'h800,
  parameter int MAX_ADD     = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata
);
  localparam int QIDX_W = $clog2(NUM_Q);

  strobe_t           wrStb;
  logic [QIDX_W-1:0] wrQ, rdQ;
  logic [DATA_W-1:0] wrVal;
  regKind_t          rdKind;

  qptr_decode #(
    .ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .REGION_BASE(REGION_BASE), .WIN_BYTES(WIN_BYTES)
  ) uDecode (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busWdata(busWdata),
    .wrStb   (wrStb),
    .wrQ     (wrQ),
    .wrVal   (wrVal),
    .rdKind  (rdKind),
    .rdQ     (rdQ)
  );

  qptr_datapath #(.NUM_Q(NUM_Q), .MAX_ADD(MAX_ADD)) uData (
    .clk   (clk),
    .rstN  (rstN),
    .wrStb (wrStb),
    .wrQ   (wrQ),
    .wrVal (wrVal),
    .rdKind(rdKind),
    .rdQ   (rdQ),
    .rdData(busRdata)
  );

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> (wrStb == '0)); // R12
  AST_BELOW_REGION_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr < ADDR_W'(REGION_BASE)) |=> (busRdata == '0)); // R2
endmodule

// File: tb/tb_qptr_ctrl.sv
module tb_qptr_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int checks = 0;
  int errors = 0;

  int mRp [256];
  int mWp [256];
  int mCode [256];
  bit mErr [256];
  bit mOvf [256];
  bit mUdf [256];

  always #5 clk = ~clk;

  qptr_ctrl dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata)
  );

  function automatic logic [23:0] qa(input int q, input int off);
    return 24'(32'h80000 + q * 32'h800 + off);
  endfunction

  function automatic int mMask(input int code);
    int lg;
    lg = (code > 18) ? 18 : code;
    return (1 << lg) - 1;
  endfunction

  function automatic logic [31:0] modelRead(input logic [23:0] a);
    int q, off;
    logic [31:0] v;
    v = '0;
    if (a < 24'h80000) return v;
    q   = int'(((a - 24'h80000) >> 11) & 24'hFF);
    off = int'(a & 24'h7FF);
    case (off)
      'h08: begin v = 32'(mRp[q]); v[31] = mErr[q]; end
      'h0C: begin v = 32'(mWp[q]); v[31] = mOvf[q]; v[30] = mUdf[q]; end
      'h10: v = 32'(mCode[q]);
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic modelWrite(input logic [23:0] a, input logic [31:0] d);
    int q, off, m, occ, n;
    if (a < 24'h80000) return;
    q   = int'(((a - 24'h80000) >> 11) & 24'hFF);
    off = int'(a & 24'h7FF);
    m   = mMask(mCode[q]);
    occ = (mWp[q] - mRp[q]) & m;
    n   = int'(d[17:0]);
    case (off)
      'h00: if (d > 63) mErr[q] = 1; else begin
              if (n > occ) mUdf[q] = 1;
              mRp[q] = (mRp[q] + n) & m;
            end
      'h04: if (d > 63) mErr[q] = 1; else begin
              if (occ + n > m) mOvf[q] = 1;
              mWp[q] = (mWp[q] + n) & m;
            end
      'h08: if (d[31]) mErr[q] = 0;
      'h0C: begin if (d[31]) mOvf[q] = 0; if (d[30]) mUdf[q] = 0; end
      'h10: begin
              mCode[q] = int'(d[4:0]);
              m = mMask(mCode[q]);
              mRp[q] = mRp[q] & m;
              mWp[q] = mWp[q] & m;
            end
      default: ;
    endcase
  endtask

  task automatic op(input string req, input logic [23:0] a, input logic we, input logic [31:0] d);
    logic [31:0] exp;
    @(negedge clk);
    busAddr = a; busWe = we; busWdata = d;
    exp = modelRead(a);
    @(posedge clk);
    #1;
    checks++;
    if (busRdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, busRdata, exp);
    end
    if (we) modelWrite(a, d);
  endtask

  function automatic string reqFor(input int off, input logic we);
    case (off)
      'h00: return "R3";
      'h04: return "R4";
      'h08: return we ? "R10" : "R6";
      'h0C: return we ? "R10" : "R8";
      'h10: return "R7";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mRp[i] = 0; mWp[i] = 0; mCode[i] = 18; mErr[i] = 0; mOvf[i] = 0; mUdf[i] = 0;
    end
    repeat (3) @(negedge clk);
    checks++;
    if (busRdata !== 32'h0) begin
      errors++;
      $display("FAIL R1 reset rdata actual=%h expected=0", busRdata);
    end
    rstN = 1'b1;
    // R1: reset contents of a few queues
    op("R1", qa(0, 'h08), 0, 0);
    op("R1", qa(0, 'h0C), 0, 0);
    op("R1", qa(0, 'h10), 0, 0);
    op("R1", qa(255, 'h0C), 0, 0);
    // R4 / R6 / R11: add to write pointer, read back next cycle
    op("R4", qa(5, 'h04), 1, 10);
    op("R11", qa(5, 'h0C), 0, 0);
    op("R3", qa(5, 'h00), 1, 4);
    op("R6", qa(5, 'h08), 0, 0);
    op("R3", qa(5, 'h00), 0, 0);
    // R4 boundary: maximum single add
    op("R4", qa(5, 'h04), 1, 63);
    op("R4", qa(5, 'h0C), 0, 0);
    // R5: rejected add
    op("R5", qa(5, 'h04), 1, 64);
    op("R5", qa(5, 'h0C), 0, 0);
    op("R5", qa(5, 'h08), 0, 0);
    op("R5", qa(5, 'h00), 1, 32'h8000_0001);
    op("R5", qa(5, 'h08), 0, 0);
    // R10: clear error; read in same cycle shows old value (R11)
    op("R11", qa(5, 'h08), 1, 32'h8000_0000);
    op("R10", qa(5, 'h08), 0, 0);
    // R7 / R8: small queue, wrap and overflow together
    op("R7", qa(7, 'h10), 1, 3);
    op("R7", qa(7, 'h10), 0, 0);
    op("R8", qa(7, 'h04), 1, 7);
    op("R8", qa(7, 'h0C), 0, 0);
    op("R8", qa(7, 'h04), 1, 2);
    op("R8", qa(7, 'h0C), 0, 0);
    // R9: underflow
    op("R9", qa(7, 'h00), 1, 5);
    op("R9", qa(7, 'h0C), 0, 0);
    // R10: clear only overflow, then only underflow
    op("R10", qa(7, 'h0C), 1, 32'h8000_0000);
    op("R10", qa(7, 'h0C), 0, 0);
    op("R10", qa(7, 'h0C), 1, 32'h4000_0000);
    op("R10", qa(7, 'h0C), 0, 0);
    // R7: size write truncates pointers
    op("R7", qa(5, 'h10), 1, 2);
    op("R7", qa(5, 'h0C), 0, 0);
    op("R7", qa(5, 'h08), 0, 0);
    // R2: aliasing, below region, undecoded offsets
    op("R2", 24'h100000 + 24'h800 * 3 + 24'h4, 1, 9);
    op("R2", qa(3, 'h0C), 0, 0);
    op("R2", 24'h000004, 1, 5);
    op("R2", 24'h000008, 0, 0);
    op("R2", qa(3, 'h14), 1, 7);
    op("R2", qa(3, 'h0C), 0, 0);
    op("R3", qa(3, 'h04), 0, 0);
    // R12: neighbours untouched, idle write data ignored
    op("R12", qa(9, 'h04), 1, 20);
    op("R12", qa(8, 'h0C), 0, 32'hFFFF_FFFF);
    op("R12", qa(10, 'h0C), 0, 0);
    op("R12", qa(9, 'h0C), 0, 0);
    op("R4", qa(255, 'h04), 1, 33);
    op("R4", qa(255, 'h0C), 0, 0);
    // Random mixed traffic on small and full-size queues
    for (int i = 0; i < 4000; i++) begin
      int q, offSel, off;
      logic we;
      logic [31:0] d;
      q = (i % 7 == 0) ? 254 + int'($urandom_range(0, 1)) : int'($urandom_range(0, 3));
      offSel = int'($urandom_range(0, 5));
      off = (offSel == 5) ? 'h14 : offSel * 4;
      we = $urandom_range(0, 2) != 0;
      case (off)
        'h00, 'h04: d = ($urandom_range(0, 9) == 0) ? 32'($urandom_range(64, 300))
                                                     : 32'($urandom_range(0, 63));
        'h10: d = ($urandom_range(0, 4) == 0) ? 32'd18 : 32'($urandom_range(0, 4));
        default: d = $urandom;
      endcase
      op(reqFor(off, we), qa(q, off), we, d);
    end
    op("R11", qa(0, 'h08), 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule